// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running timer count and a compare value loaded by software, and acts when the two become equal. The action depends on a 4-bit mode field. The output latch can be driven high or driven low. It can also be left alone while only the interrupt flag is raised. In the last mode, the block sends a one-cycle request back to the timer so that the timer restarts from zero. This restart does not raise the timer's overflow indication.

Every active mode sets a sticky interrupt flag in the same clock edge that the action takes place. The flag stays set until software pulses a clear strobe. A mode field of all zeros turns the unit off and holds the compare output latch at its default low level. This latch is separate from any port data register.

A match is detected on the rising edge of the equality condition. A timer that stalls on the compare value therefore causes only one action. The timer counter, the pin direction control and the register bus all sit outside this block.

Top module: `tcmp_match_unit`

## Requirements
- R1: While reset (active low) is asserted, the output latch, the interrupt flag and the timer-reset pulse are all 0 after the next clock edge.
- R2: A match requires all 16 bits of the timer value to equal the compare value. A timer value that differs from the compare value in any single bit causes no action, no flag and no pulse.
- R3: In mode 4'b1000, a match sets the output latch to 1. The new value is visible after the clock edge on which the match was sampled.
- R4: In mode 4'b1001, a match clears the output latch to 0 at the same edge.
- R5: In mode 4'b1010, a match sets the flag and leaves the output latch unchanged.
- R6: In mode 4'b1011, a match sets the flag, leaves the output latch unchanged and raises the timer-reset output for exactly one cycle. The timer-reset output is never high in any other mode.
- R7: Once set, the flag stays 1 until a clear strobe is sampled. It reads 0 after that edge if no match occurs at the same time.
- R8: When a clear strobe and a match are sampled at the same edge, the flag ends up 1.
- R9: Equality that holds over consecutive cycles counts as one match, on its first cycle. A new match needs equality to drop and then return.
- R10: In mode 4'b0000, the output latch reads 0 after the next edge. Equality in this mode sets neither the flag nor the timer-reset output.
- R11: In any mode other than the five listed above, equality has no effect: the latch holds, and the flag and the pulse are not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Match action select |
| cmp_val_i | input | 16 | Compare value |
| tmr_val_i | input | 16 | Current timer count |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cmp_out_o | output | 1 | Compare output latch |
| flag_o | output | 1 | Sticky interrupt flag |
| tmr_rst_o | output | 1 | One-cycle timer restart request |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. The latch, the flag and the restart pulse all update at the edge that samples the new equality. The bench drives inputs just after a falling edge and reads all three outputs at the following falling edge, which is half a period after the edge that updated them. A cycle-by-cycle model built from the requirements runs through every 4-bit mode. In each mode it covers walking single-bit mismatches, stalled equality, and clear strobes that collide with a match.

// File: rtl/tcmp_pkg.sv
// Shared widths and mode encodings for the timer compare match unit.
package tcmp_pkg;
    localparam int TMR_W  = 16;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'b0000,
        MODE_SET_HI = 4'b1000,
        MODE_SET_LO = 4'b1001,
        MODE_FLAG   = 4'b1010,
        MODE_SPEC   = 4'b1011
    } tcmp_mode_e;

    // True for modes that act on a match.
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == MODE_SET_HI) || (m == MODE_SET_LO) ||
               (m == MODE_FLAG)   || (m == MODE_SPEC);
    endfunction
endpackage

// File: rtl/tcmp_match_det.sv
// Match detector: full-width equality with a rising-edge qualifier.
// Assumes the timer and compare inputs are synchronous to clk.
// Produces a one-cycle combinational match strobe, and only in active modes.
module tcmp_match_det #(
    parameter int W = tcmp_pkg::TMR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [tcmp_pkg::MODE_W-1:0] mode_i,
    input  logic [W-1:0]                cmp_i,
    input  logic [W-1:0]                tmr_i,
    output logic                        match_o
);
    logic eq;
    logic eq_q;

    // Current equality of timer and compare value.
    assign eq = (cmp_i == tmr_i);

    // Remember last cycle's equality for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // Qualify the rising edge of equality with an active mode.
    assign match_o = eq && !eq_q && tcmp_pkg::mode_active(mode_i);

    p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
    p_match_needs_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_i != cmp_i) |-> !match_o);
endmodule

// File: rtl/tcmp_action.sv
// Action stage: the compare output latch and the timer restart pulse.
// Assumes match_i is a single-cycle strobe from the detector.
// Mode off forces the latch low; the restart pulse is registered.
module tcmp_action (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [tcmp_pkg::MODE_W-1:0] mode_i,
    input  logic                        match_i,
    output logic                        out_o,
    output logic                        trig_o
);
    import tcmp_pkg::*;

    // Set/reset latch for the compare output.
    always_ff @(posedge clk) begin
        if (!rst_n)                              out_o <= 1'b0;
        else if (mode_i == MODE_OFF)             out_o <= 1'b0;
        else if (match_i && mode_i == MODE_SET_HI) out_o <= 1'b1;
        else if (match_i && mode_i == MODE_SET_LO) out_o <= 1'b0;
    end

    // One-cycle restart request in special event mode.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= match_i && (mode_i == MODE_SPEC);
    end

    p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_i == MODE_SET_HI) |=> out_o);
    p_set_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && mode_i == MODE_SET_LO) |=> !out_o);
    p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> !out_o);
    p_trig_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
    p_trig_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_SPEC) |=> !trig_o);
endmodule

// File: rtl/tcmp_irq_flag.sv
// Sticky interrupt flag: set by a match, cleared by a software strobe.
// Assumes match_i is already qualified by mode; a match wins over a clear.
module tcmp_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (match_i) flag_o <= 1'b1;
        else if (clr_i)   flag_o <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> flag_o);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tcmp_match_unit.sv
// Top of the timer compare match unit: detector, action stage and flag.
// Assumes the timer, the pin buffer and the register access sit outside.
module tcmp_match_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  mode_i,
    input  logic [15:0] cmp_val_i,
    input  logic [15:0] tmr_val_i,
    input  logic        flag_clr_i,
    output logic        cmp_out_o,
    output logic        flag_o,
    output logic        tmr_rst_o
);
    logic match;

    tcmp_match_det #(.W(tcmp_pkg::TMR_W)) u_det (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cmp_i(cmp_val_i), .tmr_i(tmr_val_i), .match_o(match)
    );

    tcmp_action u_act (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .match_i(match), .out_o(cmp_out_o), .trig_o(tmr_rst_o)
    );

    tcmp_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match_i(match),
        .clr_i(flag_clr_i), .flag_o(flag_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!cmp_out_o && !flag_o && !tmr_rst_o));
endmodule

// File: tb/tcmp_match_unit_tb_top.sv
`timescale 1ns/1ps
module tcmp_match_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] cmp = 16'd0;
    logic [15:0] tmr = 16'd1;
    logic        clr = 1'b0;
    logic        out_w, flag_w, trig_w;

    int n_chk = 0;
    int n_bad = 0;
    logic m_out = 0, m_flag = 0, m_trig = 0, m_prev = 0;

    always #2 clk = ~clk;

    tcmp_match_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_val_i(cmp),
        .tmr_val_i(tmr), .flag_clr_i(clr), .cmp_out_o(out_w),
        .flag_o(flag_w), .tmr_rst_o(trig_w)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s mode=%b: got %b expected %b", tag, what, mode, act, exp);
        end
    endtask

    // Advance one cycle; update the requirement model; compare at the falling edge.
    task automatic tick(input string tag);
        logic eq, act, mt;
        eq  = (cmp == tmr);
        act = (mode == 4'b1000) || (mode == 4'b1001) || (mode == 4'b1010) || (mode == 4'b1011);
        mt  = eq && !m_prev && act;
        if (mode == 4'b0000)              m_out = 1'b0;
        else if (mt && mode == 4'b1000)   m_out = 1'b1;
        else if (mt && mode == 4'b1001)   m_out = 1'b0;
        if (mt)       m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        m_trig = mt && (mode == 4'b1011);
        m_prev = eq;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "out",  out_w,  m_out);
        chk(tag, "flag", flag_w, m_flag);
        chk(tag, "trig", trig_w, m_trig);
    endtask

    function automatic string mode_tag(input logic [3:0] m);
        case (m)
            4'b0000: return "R10";
            4'b1000: return "R3";
            4'b1001: return "R4";
            4'b1010: return "R5";
            4'b1011: return "R6";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string t;
        // R1: reset state
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "out", out_w, 1'b0);
        chk("R1", "flag", flag_w, 1'b0);
        chk("R1", "trig", trig_w, 1'b0);
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++) begin
            cmp = 16'h1234 + 16'(m * 16'h0F1B);
            // Preload the latch high so that low-forcing modes are visible.
            mode = 4'b1000; tmr = cmp - 16'd1; tick("R3");
            tmr = cmp; tick("R3");
            tmr = cmp + 16'd1; tick("R3");
            mode = 4'(m); clr = 1'b1; tick("R7");
            clr = 1'b0;
            t = mode_tag(4'(m));
            // R2: walking single-bit mismatch
            for (int b = 0; b < 16; b++) begin
                tmr = cmp ^ (16'd1 << b); tick("R2");
            end
            // Match, then stall on equality (R9)
            tmr = cmp; tick(t);
            for (int s = 0; s < 3; s++) tick("R9");
            // Clear while equality is still stalled
            clr = 1'b1; tick("R7"); clr = 1'b0;
            tmr = cmp - 16'd1; tick(t);
            // Clear colliding with a new match (R8)
            clr = 1'b1; tmr = cmp; tick("R8"); clr = 1'b0;
            tmr = cmp + 16'd2; tick(t);
            clr = 1'b1; tick("R7"); clr = 1'b0;
            tick("R7");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule